// File: doc/BRIEF.md
# Configurable-Frame SPI Master Shift Engine

This block is the shifting core of an SPI master. A small configuration register sets the clock phase, the idle level of the serial clock and the frame length, which can be anywhere from 1 to 8 bits. A read-only field in the same register shows how many bits of the current or most recent frame have been sampled. Writing a word to the data register while the engine is idle starts a frame. The engine lowers its active-low select, shifts the top bits of the word out on MOSI MSB-first and captures the same number of bits from MISO. It then pulses `done` and releases the select.

The serial clock rate is not set inside the block. A clock-enable input `tick` comes from an external divider. Each clock cycle with `tick` high moves SCK by exactly one edge, so one bit takes two ticks. The sequencer has four states:
- `ST_IDLE`: select high, SCK at the configured idle level.
- `ST_LEAD`: waiting for the tick that makes the leading SCK edge.
- `ST_TRAIL`: waiting for the tick that makes the trailing SCK edge.
- `ST_DONE`: a single-cycle completion state.

The transitions are:
- start: `ST_IDLE` to `ST_LEAD`.
- lead-edge: `ST_LEAD` to `ST_TRAIL`.
- next-bit: `ST_TRAIL` to `ST_LEAD`.
- last-bit: `ST_TRAIL` to `ST_DONE`.
- release: `ST_DONE` to `ST_IDLE`.

Top module: `spi_frame_master`

## Requirements
- R1: After reset the configuration register reads 0x07, which is phase 0, polarity 0, bit count 0 and frame code 7 (8 bits). The data register reads 0, `cs_n` is 1, `busy` and `done` are 0 and `sck` is 0.
- R2: While idle, `sck` equals the polarity bit (bit 6 of the configuration register). During a frame the leading edge moves SCK away from that level and the trailing edge returns it.
- R3: The frame code in bits 2:0, with value N, makes a frame of N+1 bits. A frame has exactly 2(N+1) SCK edges.
- R4: The bit-count field in bits 5:3 is read-only. It reads 0 from reset and from the start of a frame until the first sample. After k samples it reads k-1, and it holds its value after the frame ends. Writes to bits 5:3 do not change it.
- R5: With phase bit (bit 7) at 0, MOSI carries the frame's top bit from the cycle after the start. MISO is sampled on each leading edge, and MOSI moves to the next bit on each trailing edge that is not the last.
- R6: With phase bit at 1, MOSI changes to the next bit on each leading edge, and MISO is sampled on each trailing edge.
- R7: For a frame of n bits, bits n-1 down to 0 of the written word leave in that order. The n received bits are right-justified in the data register, the first received bit is the most significant, and the upper bits are 0. The data register holds this value when `done` is high.
- R8: A data write while `busy` is low starts a frame, and `busy` is high and `cs_n` low from the next cycle. A data write while `busy` is high is ignored, and no further frame follows.
- R9: `done` is high for exactly one cycle. It starts at the clock edge that returns SCK to idle after the final bit. On the next cycle `busy` is 0 and `cs_n` is 1.
- R10: A configuration write during a frame shows at once in the read-back. The running frame keeps the phase, polarity and length it started with, and the next frame uses the new settings.
- R11: During a frame SCK changes only on clock edges for which `tick` was high, and each such tick moves it by one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Clock enable setting the SCK edge rate |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | CFG_W (8) | Configuration write data |
| cfg_rdata | output | CFG_W (8) | Configuration read-back including live bit count |
| dat_wr | input | 1 | Data write strobe; starts a frame when idle |
| dat_wdata | input | DATA_W (8) | Word to transmit |
| dat_rdata | output | DATA_W (8) | Received bits, right-justified |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select |

## Verification
A data write shows as `busy` high and `cs_n` low one clock later. Each SCK edge appears one clock after the cycle in which `tick` was high. `done` rises at the same edge that returns SCK to idle after the final bit, and the select is released one clock after that. The bench drives and reads every signal at falling clock edges. It checks the start, every SCK edge, the `done` cycle and the following release cycle at the first falling edge after the rising edge that produces each of them. The expected word for each frame is queued when the frame is issued and compared at `done`, so there is never more than one item outstanding.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

    // Sequencer states: idle, waiting for leading edge, waiting for
    // trailing edge, one-cycle completion.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2,
        ST_DONE  = 2'd3
    } xfer_state_e;

endpackage

// File: rtl/spi_cfg_store.sv
module spi_cfg_store #(
    parameter  int CNT_W = 3,
    localparam int CFG_W = 2 + 2 * CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    input  logic [CNT_W-1:0] bitcnt,
    output logic             pha,
    output logic             pol,
    output logic [CNT_W-1:0] size,
    output logic [CFG_W-1:0] rdata
);

    localparam int PHA_B = CFG_W - 1;
    localparam int POL_B = CFG_W - 2;

    // Bit-count bits of wdata are not stored: the field is read-only (R4).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pha  <= 1'b0;
            pol  <= 1'b0;
            size <= '1;
        end else if (wr_en) begin
            pha  <= wdata[PHA_B];
            pol  <= wdata[POL_B];
            size <= wdata[CNT_W-1:0];
        end
    end

    assign rdata = {pha, pol, bitcnt, size};

endmodule

// File: rtl/spi_bit_seq.sv
module spi_bit_seq
    import spi_frame_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_req,
    input  logic             tick,
    input  logic             cfg_pha,
    input  logic             cfg_pol,
    input  logic [CNT_W-1:0] cfg_size,
    output logic             load,
    output logic             sample_en,
    output logic             drive_en,
    output logic [CNT_W-1:0] bitcnt,
    output logic             sck,
    output logic             cs_n,
    output logic             busy,
    output logic             done
);

    localparam logic [CNT_W:0] ONE_L = (CNT_W + 1)'(1);

    xfer_state_e    state_q, state_d;
    logic           act_pha_q, act_pol_q;
    logic [CNT_W:0] left_q;
    logic [CNT_W:0] smp_q;
    logic           sck_q;
    logic           last_bit;

    assign last_bit = (left_q == ONE_L);
    assign load     = go_req && (state_q == ST_IDLE);

    // Next-state and edge strobes
    always_comb begin
        state_d   = state_q;
        sample_en = 1'b0;
        drive_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (load) state_d = ST_LEAD;
            end
            ST_LEAD: begin
                if (tick) begin
                    state_d = ST_TRAIL;
                    if (act_pha_q) drive_en  = 1'b1;
                    else           sample_en = 1'b1;
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    if (act_pha_q) sample_en = 1'b1;
                    if (last_bit) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_LEAD;
                        if (!act_pha_q) drive_en = 1'b1;
                    end
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Frame snapshot, bit counters and clock level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_pha_q <= 1'b0;
            act_pol_q <= 1'b0;
            left_q    <= '0;
            smp_q     <= '0;
            sck_q     <= 1'b0;
        end else if (load) begin
            act_pha_q <= cfg_pha;
            act_pol_q <= cfg_pol;
            left_q    <= (CNT_W + 1)'(cfg_size) + ONE_L;
            smp_q     <= '0;
            sck_q     <= cfg_pol;
        end else begin
            if (state_q == ST_LEAD && tick) sck_q <= ~act_pol_q;
            if (state_q == ST_TRAIL && tick) begin
                sck_q <= act_pol_q;
                if (!last_bit) left_q <= left_q - ONE_L;
            end
            if (sample_en) smp_q <= smp_q + ONE_L;
        end
    end

    // Outputs
    always_comb begin
        cs_n   = (state_q == ST_IDLE);
        busy   = (state_q != ST_IDLE);
        done   = (state_q == ST_DONE);
        sck    = (state_q == ST_IDLE) ? cfg_pol : sck_q;
        bitcnt = (smp_q == '0) ? '0 : CNT_W'(smp_q - ONE_L);
    end

endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path #(
    parameter  int DATA_W = 8,
    localparam int CNT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cfg_pha,
    input  logic [CNT_W-1:0]  cfg_size,
    input  logic              drive_en,
    input  logic              sample_en,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data
);

    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic [CNT_W-1:0]  nxt_q;
    logic              mosi_q;

    // Transmit side: pointer walks down from the top of the frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= '0;
            nxt_q  <= '0;
            mosi_q <= 1'b0;
        end else if (load) begin
            tx_q <= wdata;
            if (cfg_pha) begin
                nxt_q <= cfg_size;
            end else begin
                mosi_q <= wdata[cfg_size];
                nxt_q  <= cfg_size - CNT_W'(1);
            end
        end else if (drive_en) begin
            mosi_q <= tx_q[nxt_q];
            nxt_q  <= nxt_q - CNT_W'(1);
        end
    end

    // Receive side: shift left, so n samples land right-justified
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (load) begin
            rx_q <= '0;
        end else if (sample_en) begin
            rx_q <= {rx_q[DATA_W-2:0], miso};
        end
    end

    assign mosi    = mosi_q;
    assign rx_data = rx_q;

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
    parameter  int DATA_W = 8,
    localparam int CNT_W  = $clog2(DATA_W),
    localparam int CFG_W  = 2 + 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] dat_wdata,
    output logic [DATA_W-1:0] dat_rdata,
    output logic              busy,
    output logic              done,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);

    logic             c_pha, c_pol;
    logic [CNT_W-1:0] c_size;
    logic [CNT_W-1:0] bitcnt;
    logic             load, sample_en, drive_en;

    spi_cfg_store #(.CNT_W(CNT_W)) cfg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr),
        .wdata  (cfg_wdata),
        .bitcnt (bitcnt),
        .pha    (c_pha),
        .pol    (c_pol),
        .size   (c_size),
        .rdata  (cfg_rdata)
    );

    spi_bit_seq #(.CNT_W(CNT_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_req    (dat_wr),
        .tick      (tick),
        .cfg_pha   (c_pha),
        .cfg_pol   (c_pol),
        .cfg_size  (c_size),
        .load      (load),
        .sample_en (sample_en),
        .drive_en  (drive_en),
        .bitcnt    (bitcnt),
        .sck       (sck),
        .cs_n      (cs_n),
        .busy      (busy),
        .done      (done)
    );

    spi_shift_path #(.DATA_W(DATA_W)) path_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .wdata     (dat_wdata),
        .cfg_pha   (c_pha),
        .cfg_size  (c_size),
        .drive_en  (drive_en),
        .sample_en (sample_en),
        .miso      (miso),
        .mosi      (mosi),
        .rx_data   (dat_rdata)
    );

endmodule

// File: rtl/spi_frame_master_chk.sv
module spi_frame_master_chk #(
    parameter  int DATA_W = 8,
    localparam int CNT_W  = $clog2(DATA_W),
    localparam int CFG_W  = 2 + 2 * CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             dat_wr,
    input logic             busy,
    input logic             done,
    input logic             sck,
    input logic             cs_n,
    input logic [CFG_W-1:0] cfg_rdata
);

    // R9: completion pulse lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: bus released right after completion
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && cs_n));

    // R8: idle data write starts a frame
    a_r8_start: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !busy) |=> (busy && !cs_n));

    // R2: idle clock level follows the polarity bit
    a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == cfg_rdata[CFG_W-2]));

    // R11: no SCK movement without a tick
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !tick) |=> $stable(sck));

endmodule

bind spi_frame_master spi_frame_master_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .dat_wr    (dat_wr),
    .busy      (busy),
    .done      (done),
    .sck       (sck),
    .cs_n      (cs_n),
    .cfg_rdata (cfg_rdata)
);

// File: tb/spi_frame_master_tb_top.sv
module spi_frame_master_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       dat_wr = 1'b0;
    logic [7:0] dat_wdata = '0;
    logic [7:0] dat_rdata;
    logic       busy, done, sck, mosi, cs_n;
    logic       miso = 1'b0;

    always #2 clk = ~clk;

    spi_frame_master dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .busy(busy), .done(done), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    typedef struct {
        logic [7:0] tx_bits;
        logic [7:0] rx_bits;
        int         n;
    } item_t;

    item_t      q[$];
    int         n_chk = 0;
    int         n_bad = 0;
    int         done_cnt = 0;
    bit         tick_on = 1'b1;
    bit         cur_pha = 1'b0, cur_pol = 1'b0;
    int         cur_n = 8;
    logic [7:0] cur_tx = '0, s_word = '0;
    logic [7:0] cap = '0;
    int         edges = 0;
    int         pos = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // Tick source: one cycle in three, gated by tick_on
    initial begin
        int tdiv = 0;
        forever begin
            @(negedge clk);
            tdiv = (tdiv + 1) % 3;
            tick = tick_on && (tdiv == 0);
        end
    end

    // Slave model and scoreboard monitor
    initial begin
        logic sck_prev = 1'b0;
        logic cs_prev  = 1'b1;
        bit   post     = 1'b0;
        bit   lead;
        item_t it;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (post) begin
                    chk("R9", "done after pulse", int'(done), 0);
                    chk("R9", "busy after pulse", int'(busy), 0);
                    chk("R9", "cs_n after pulse", int'(cs_n), 1);
                    post = 1'b0;
                end
                if (cs_prev && !cs_n) begin
                    pos   = cur_n - 1;
                    miso  = s_word[pos];
                    cap   = '0;
                    edges = 0;
                    chk("R4", "bit count at start", int'(cfg_rdata[5:3]), 0);
                    if (!cur_pha)
                        chk("R5", "top bit before first edge", int'(mosi), int'(cur_tx[cur_n-1]));
                end else if (!cs_n && sck != sck_prev) begin
                    edges++;
                    lead = (sck_prev == cur_pol);
                    if (lead ^ cur_pha) begin
                        cap = {cap[6:0], mosi};
                        pos--;
                        miso = (pos >= 0) ? s_word[pos] : 1'b0;
                    end
                end
                if (done) begin
                    if (q.size() == 0) begin
                        chk("R9", "unexpected done", 1, 0);
                    end else begin
                        it = q.pop_front();
                        chk(cur_pha ? "R6" : "R5", "sampled mosi word", int'(cap), int'(it.tx_bits));
                        chk("R7", "received word", int'(dat_rdata), int'(it.rx_bits));
                        chk("R3", "sck edge count", edges, 2 * it.n);
                        chk("R4", "bit count at end", int'(cfg_rdata[5:3]), it.n - 1);
                        chk("R9", "sck idle at done", int'(sck), int'(cur_pol));
                        chk("R9", "cs_n at done", int'(cs_n), 0);
                    end
                    post = 1'b1;
                    done_cnt++;
                end
                sck_prev = sck;
                cs_prev  = cs_n;
            end
        end
    end

    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_wdata = v;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic wr_dat(input logic [7:0] v);
        @(negedge clk);
        dat_wdata = v;
        dat_wr    = 1'b1;
        @(negedge clk);
        dat_wr    = 1'b0;
    endtask

    // mode 0 plain, 1 data write while busy, 2 config write while busy, 3 tick pause
    task automatic run_xfer(input bit pha, input bit pol, input int code,
                            input logic [7:0] tx, input logic [7:0] sw,
                            input bit wcfg, input int mode);
        item_t it;
        int n = code + 1;
        int target;
        logic [7:0] m = 8'((9'd1 << n) - 9'd1);
        logic s;
        if (wcfg) wr_cfg({pha, pol, 3'b000, 3'(code)});
        chk("R2", "idle sck level", int'(sck), int'(pol));
        cur_pha = pha; cur_pol = pol; cur_n = n; cur_tx = tx; s_word = sw;
        it.tx_bits = tx & m;
        it.rx_bits = sw & m;
        it.n       = n;
        q.push_back(it);
        target = done_cnt + 1;
        wr_dat(tx);
        chk("R8", "busy after start", int'(busy), 1);
        case (mode)
            1: begin
                repeat (3) @(negedge clk);
                wr_dat(8'h00);
            end
            2: begin
                repeat (4) @(negedge clk);
                wr_cfg(8'b11_000_011);
                chk("R10", "new phase/polarity read back", int'(cfg_rdata[7:6]), 3);
                chk("R10", "new frame code read back", int'(cfg_rdata[2:0]), 3);
            end
            3: begin
                tick_on = 1'b0;
                repeat (2) @(negedge clk);
                s = sck;
                repeat (8) @(negedge clk);
                chk("R11", "sck held without tick", int'(sck), int'(s));
                chk("R11", "still busy without tick", int'(busy), 1);
                tick_on = 1'b1;
            end
            default: ;
        endcase
        wait (done_cnt == target);
        repeat (2) @(negedge clk);
        if (mode == 1) begin
            repeat (10) @(negedge clk);
            chk("R8", "no frame from busy write", int'(busy), 0);
            chk("R8", "no extra done", done_cnt, target);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R8 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "config reset value", int'(cfg_rdata), 8'h07);
        chk("R1", "data reset value", int'(dat_rdata), 0);
        chk("R1", "cs_n at reset", int'(cs_n), 1);
        chk("R1", "busy at reset", int'(busy), 0);
        chk("R1", "done at reset", int'(done), 0);
        chk("R1", "sck at reset", int'(sck), 0);
        wr_cfg(8'h3F);
        chk("R4", "bit count write ignored", int'(cfg_rdata), 8'h07);

        run_xfer(1'b0, 1'b0, 7, 8'hA5, 8'h3C, 1'b1, 0);
        wr_cfg(8'b00_000_111);
        chk("R4", "bit count holds after write", int'(cfg_rdata[5:3]), 7);

        run_xfer(1'b1, 1'b0, 7, 8'h96, 8'hC3, 1'b1, 0);
        run_xfer(1'b0, 1'b1, 4, 8'h1B, 8'h15, 1'b1, 0);
        run_xfer(1'b1, 1'b1, 0, 8'hFF, 8'h80, 1'b1, 0);
        run_xfer(1'b0, 1'b0, 2, 8'h05, 8'h06, 1'b1, 1);
        run_xfer(1'b0, 1'b0, 7, 8'h5A, 8'hE1, 1'b1, 2);
        chk("R10", "idle level from new config", int'(sck), 1);
        run_xfer(1'b1, 1'b1, 3, 8'h0C, 8'h09, 1'b0, 0);
        run_xfer(1'b1, 1'b0, 5, 8'h2D, 8'h33, 1'b1, 3);

        summary();
        $finish;
    end

endmodule